// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Tap

This block is one tap of a low-power FIR datapath that works on one bit per clock. A serial sample stream is multiplied by a small parallel coefficient. The product stream is added to a second serial stream, which is the partial sum arriving from a neighbouring tap. The sum is collected in a 16-bit result register. Every stream is least significant bit first. Each multiplier cell is a single AND gate feeding a full adder, and that adder's carry returns to itself through one flip-flop. The serial adder follows the same pattern with its own carry flip-flop.

A word begins with a `start` pulse. The pulse clears the bit counter, every carry flip-flop and the sample delay line. It leaves the result register as it is. Bit pairs then enter through a valid/ready handshake:
- A beat transfers only in a cycle where `s_valid` and `s_ready` are both high and `start` is low.
- Holding `s_valid` low stalls the datapath with no effect on the arithmetic.
- After 16 beats have transferred, `done` rises and `s_ready` falls. No further beat is taken until the next `start`, which is how back-pressure reaches the source.

The coefficient must stay stable for the whole word.

Top module: `serial_mac_tap`

## Requirements
- R1: After reset is released, `result` is 0, `done` is 0 and `s_ready` is 1. The block is then ready to take a word, as if it had just been started.
- R2: A cycle with `start` high clears the beat counter, all multiplier and adder carries, and the sample delay line. A word that was interrupted part-way therefore has no effect on the next word's result.
- R3: After 16 transferred beats, `result` equals (X*C + Y) mod 2^16. Here X and Y are the 16-bit words presented on `x_bit` and `y_bit`, least significant bit first, and C is `coef` read as an unsigned integer.
- R4: On each transferred beat the new sum bit enters `result[15]` and the register shifts right, so the sum bit of the first beat ends in `result[0]`.
- R5: `done` is high exactly when 16 beats have transferred since the last `start` or reset. `s_ready` is always the inverse of `done`.
- R6: A beat transfers only when `s_valid`, `s_ready` and not `start` all hold. In a cycle with `s_valid` low, `result`, `done` and the multiplier state do not change, so gaps in the stream do not alter the final result.
- R7: While `done` is high and `start` is low, `result` and `done` hold their values whatever appears on the serial inputs.
- R8: Serial bits present in a cycle where `start` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new word; clears counter, carries and delay line |
| coef | input | 4 | Unsigned coefficient, held stable during a word |
| s_valid | input | 1 | Serial bit pair on `x_bit`/`y_bit` is valid |
| s_ready | output | 1 | Block can take a bit pair (inverse of `done`) |
| x_bit | input | 1 | Sample stream bit, LSB first |
| y_bit | input | 1 | Incoming partial-sum stream bit, LSB first |
| result | output | 16 | Accumulated word, right-shifting shift register |
| done | output | 1 | 16 beats have transferred since the last start |

## Verification
The arithmetic is tried with random sample and partial-sum words across random coefficients, and with the extreme coefficients 0 and 15 against all-ones and sign-bit-only words. These cases exercise the longest carry chains in both the multiplier cells and the serial adder. Every word runs once with a continuous stream and again with random `s_valid` gaps carrying garbage bits. Equal results in both runs show that stalls are transparent. Extra beats driven while `done` is high, garbage bits presented during `start`, and a word aborted after a few beats each show whether stale state leaks into the next result. A behavioural model tracks the expected shift-register contents, `done` and `s_ready` on every clock.

// File: rtl/smt_pkg.sv
package smt_pkg;

  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (a & ci) | (b & ci);
  endfunction

endpackage

// File: rtl/smt_ctrl.sv
module smt_ctrl #(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic s_valid,
  output logic s_ready,
  output logic done,
  output logic clr,
  output logic adv
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt_q;

  assign done    = (cnt_q == CNT_FULL);
  assign s_ready = ~done;
  assign clr     = start;
  assign adv     = s_valid & ~done & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + CNT_W'(1);
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0) && !done);
  p_beat_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !start) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/smt_mult.sv
module smt_mult #(
  parameter int COEF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [COEF_W-1:0] coef,
  input  logic              x_bit,
  output logic              p_bit
);
  import smt_pkg::*;

  // xd_q[j] holds the sample bit from j+1 transferred beats ago
  logic [COEF_W-2:0] xd_q;
  logic [COEF_W-1:0] tap;
  logic [COEF_W-1:0] cy_q;
  logic [COEF_W-1:0] cy_d;
  logic [COEF_W:0]   chain;

  assign tap[0]   = x_bit;
  assign chain[0] = 1'b0;

  for (genvar i = 1; i < COEF_W; i++) begin : g_tap
    assign tap[i] = xd_q[i-1];
  end

  // one cell per coefficient bit: AND partial product, full adder, own carry flop
  for (genvar i = 0; i < COEF_W; i++) begin : g_cell
    logic pp;
    assign pp         = coef[i] & tap[i];
    assign chain[i+1] = fa_sum(pp, chain[i], cy_q[i]);
    assign cy_d[i]    = fa_carry(pp, chain[i], cy_q[i]);
  end

  assign p_bit = chain[COEF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xd_q <= '0;
      cy_q <= '0;
    end else if (clr) begin
      xd_q <= '0;
      cy_q <= '0;
    end else if (adv) begin
      xd_q <= tap[COEF_W-2:0];
      cy_q <= cy_d;
    end
  end

  p_clr_carries_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cy_q == '0) && (xd_q == '0));
  p_stall_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cy_q) && $stable(xd_q));
endmodule

// File: rtl/smt_sadd.sv
module smt_sadd #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              a_bit,
  input  logic              b_bit,
  output logic [WORD_W-1:0] acc
);
  import smt_pkg::*;

  logic cy_q;
  logic sum;

  assign sum = fa_sum(a_bit, b_bit, cy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      acc  <= '0;
    end else if (clr) begin
      cy_q <= 1'b0;
    end else if (adv) begin
      cy_q <= fa_carry(a_bit, b_bit, cy_q);
      acc  <= {sum, acc[WORD_W-1:1]};
    end
  end

  p_clr_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !cy_q);
  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> acc[WORD_W-2:0] == $past(acc[WORD_W-1:1]));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc));
endmodule

// File: rtl/serial_mac_tap.sv
module serial_mac_tap #(
  parameter int COEF_W = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COEF_W-1:0] coef,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              x_bit,
  input  logic              y_bit,
  output logic [WORD_W-1:0] result,
  output logic              done
);
  logic clr;
  logic adv;
  logic p_bit;

  smt_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
    .s_ready(s_ready), .done(done), .clr(clr), .adv(adv)
  );

  smt_mult #(.COEF_W(COEF_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .coef(coef), .x_bit(x_bit), .p_bit(p_bit)
  );

  smt_sadd #(.WORD_W(WORD_W)) u_sadd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .a_bit(p_bit), .b_bit(y_bit), .acc(result)
  );

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(result) && done);
  p_start_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> $stable(result));
endmodule

// File: tb/serial_mac_tap_bench.sv
`timescale 1ns/1ps
module serial_mac_tap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  coef = '0;
  logic        s_valid = 1'b0;
  logic        x_bit = 1'b0;
  logic        y_bit = 1'b0;
  logic        s_ready;
  logic [15:0] result;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int          m_cnt = 0;
  int          m_x = 0;
  int          m_y = 0;
  logic [15:0] m_res = '0;

  always #2 clk = ~clk;

  serial_mac_tap u_serial_mac_tap (
    .clk(clk), .rst_n(rst_n), .start(start), .coef(coef),
    .s_valid(s_valid), .s_ready(s_ready), .x_bit(x_bit), .y_bit(y_bit),
    .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(result == m_res, "R3 R4 result per cycle", int'(result), int'(m_res));
    chk(done == (m_cnt == 16), "R5 done", int'(done), int'(m_cnt == 16));
    chk(s_ready == (m_cnt != 16), "R5 s_ready", int'(s_ready), int'(m_cnt != 16));
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit st, input bit v, input bit xb, input bit yb);
    bit acc;
    int full;
    start = st; s_valid = v; x_bit = xb; y_bit = yb;
    acc = v && (m_cnt != 16) && !st;
    @(posedge clk);
    if (st) begin
      m_cnt = 0; m_x = 0; m_y = 0;
    end else if (acc) begin
      m_x = m_x | (int'(xb) << m_cnt);
      m_y = m_y | (int'(yb) << m_cnt);
      full = m_x * int'(coef) + m_y;
      m_res = {1'((full >> m_cnt) & 1), m_res[15:1]};
      m_cnt++;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_word(input logic [15:0] xw, input logic [15:0] yw, input int gap_pct);
    int k = 0;
    int exp;
    cyc(1'b1, 1'b1, 1'($urandom), 1'($urandom)); // R8: bits during start discarded
    while (k < 16) begin
      if (int'($urandom % 100) < gap_pct) begin
        cyc(1'b0, 1'b0, 1'($urandom), 1'($urandom)); // R6 stall with garbage
      end else begin
        cyc(1'b0, 1'b1, xw[k], yw[k]);
        k++;
      end
    end
    exp = (int'(xw) * int'(coef) + int'(yw)) & 'hFFFF;
    chk(result == 16'(exp), "R3 final word", int'(result), exp);
    chk(done == 1'b1, "R5 done after 16 beats", int'(done), 1);
    for (int j = 0; j < 3; j++) cyc(1'b0, 1'b1, 1'($urandom), 1'($urandom)); // R7
    chk(result == 16'(exp), "R7 result held while done", int'(result), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 16'h0, "R1 reset result", int'(result), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(s_ready == 1'b1, "R1 reset s_ready", int'(s_ready), 1);

    // corner coefficients and operands
    coef = 4'd15; run_word(16'hFFFF, 16'hFFFF, 0);
    coef = 4'd0;  run_word(16'hFFFF, 16'h1234, 0);
    coef = 4'd15; run_word(16'h8000, 16'h8000, 30);
    coef = 4'd1;  run_word(16'h0001, 16'hFFFF, 0);

    // R2: aborted word leaves no trace
    coef = 4'd13;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 7; j++) cyc(1'b0, 1'b1, 1'b1, 1'b1);
    run_word(16'h0F0F, 16'h00FF, 0);

    // random words, continuous then gapped
    for (int n = 0; n < 40; n++) begin
      logic [15:0] xr, yr;
      xr = 16'($urandom); yr = 16'($urandom);
      coef = 4'($urandom);
      run_word(xr, yr, 0);
      run_word(xr, yr, 40);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R5 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule